// File: doc/BRIEF.md
# FIFO throughput diagnostic pattern generator

This block produces a stream of test words for the write side of a FIFO. A link under test can then be judged by looking only at the words that come out at the far end. The low field of each word is a sequence number. It advances by exactly one for every word the block actually writes, so a gap in the received numbers means a word was lost. The high field carries live metadata about the FIFO, chosen by a mode input. It holds either the FIFO's current fill level, or a running count of words already read from the FIFO's output. The analyser can therefore see how the backlog grows over time.

Two knobs stress the path in different ways. The first is a reduced-rate mode, which writes on three cycles and then skips one, in a repeating pattern. This makes the FIFO run below full rate and exposes problems caused by rate mismatch. The second is a stop-on-full mode, which holds the sequence number and suppresses writes while the FIFO reports full. With stop-on-full off, the generator keeps writing into a full FIFO on purpose, so the loss appears as a gap in the sequence. The block also gives two coarse occupancy flags, derived from the fill level at 30 % and 70 % of the FIFO depth.

Top module: `fifo_probe_gen`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, wr_en is 0 and wr_data is all zeros. The read counter and the sequence number both restart from 0.
- R2: When run is 1, rate_reduce is 0 and no full-stop applies, wr_en is 1 on every cycle. Each write is the registered result of the inputs one clock earlier.
- R3: wr_data[15:0] is the sequence number. It increases by one (mod 2^16) from each written word to the next, and it starts at 0. wr_data does not change on cycles where wr_en is 0.
- R4: When meta_mode is 0, wr_data[31:16] of a written word holds the number of cycles with fifo_rd = 1 before the cycle that decided the write, taken mod 2^16.
- R5: When meta_mode is 1, wr_data[31:16] of a written word holds fifo_level zero-extended. The level is the one present in the cycle that decided the write.
- R6: When rate_reduce is 1 and run is 1, cycles are counted in groups of four. The count starts at the first cycle in which both are 1. The first three cycles of each group write and the fourth does not, so there are never more than three writes in a row.
- R7: When stop_on_full is 1 and fifo_full is 1 in a cycle, no write results from that cycle and the sequence number holds.
- R8: When stop_on_full is 0, writes continue while fifo_full is 1 and the sequence number keeps advancing, so words dropped by the FIFO show up as gaps.
- R9: occ_low is 1 exactly when fifo_level <= floor(0.3*DEPTH), which is 76 for the default depth of 256. occ_high is 1 exactly when fifo_level >= floor(0.7*DEPTH), which is 179. Both follow fifo_level with no added delay.
- R10: While run is 0, no writes occur, the sequence number holds, and the four-cycle grouping restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the FIFO write side |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables generation |
| rate_reduce | input | 1 | Selects the three-of-four write pattern |
| stop_on_full | input | 1 | Suppresses writes while the FIFO is full |
| meta_mode | input | 1 | High-field source: 0 = read count, 1 = fill level |
| fifo_full | input | 1 | Full flag of the FIFO |
| fifo_rd | input | 1 | One per word taken from the FIFO output |
| fifo_level | input | 9 | Current number of words in the FIFO |
| wr_en | output | 1 | FIFO write enable |
| wr_data | output | 32 | FIFO write word: metadata high, sequence low |
| occ_low | output | 1 | Fill level at or below the low threshold |
| occ_high | output | 1 | Fill level at or above the high threshold |

## Verification
The hardest state to reach is a FIFO that is actually full while the generator is still trying to write. That state is needed to show both that stop-on-full holds the sequence and that free-running mode leaves a gap. The bench models the FIFO, which is fed by the generator's own writes. It throttles the random read strobe to a low probability until the modelled level saturates at the depth. A second hard case is the wrap of the 16-bit read counter. A long stretch with a read on nearly every cycle drives it past 65536, while every cycle's word is compared with the modelled value.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
   typedef enum logic {
      META_CONSUMED = 1'b0,
      META_FILL     = 1'b1
   } meta_mode_e;

   function automatic int unsigned pct_of(input int unsigned depth, input int unsigned pct);
      return (depth * pct) / 100;
   endfunction
endpackage

// File: rtl/fpg_duty.sv
module fpg_duty #(
   parameter int unsigned PERIOD = 4,
   parameter int unsigned ON     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic slot
);
   initial begin : prm
      assert (PERIOD >= 1 && ON >= 1 && ON <= PERIOD)
         else $fatal(1, "fpg_duty: bad PERIOD/ON");
   end

   generate
      if (PERIOD == 1) begin : g_flat
         assign slot = 1'b1;
      end else begin : g_count
         localparam int unsigned PH_W = $clog2(PERIOD);
         localparam logic [PH_W-1:0] LAST  = PH_W'(PERIOD - 1);
         localparam logic [PH_W-1:0] ON_LM = PH_W'(ON - 1);
         logic [PH_W-1:0] phase;

         always_ff @(posedge clk) begin
            if (!rst_n || !active) begin
               phase <= '0;
            end else if (phase == LAST) begin
               phase <= '0;
            end else begin
               phase <= phase + 1'b1;
            end
         end

         assign slot = !active || (phase <= ON_LM);
      end
   endgenerate
endmodule

// File: rtl/fpg_meta.sv
module fpg_meta #(
   parameter int unsigned META_W = 16,
   parameter int unsigned LVL_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_rd,
   input  logic [LVL_W-1:0]  fifo_level,
   input  fpg_pkg::meta_mode_e mode,
   output logic [META_W-1:0] meta
);
   initial begin : prm
      assert (LVL_W >= 1 && LVL_W <= META_W)
         else $fatal(1, "fpg_meta: level does not fit metadata field");
   end

   logic [META_W-1:0] consumed;
   logic [META_W-1:0] level_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         consumed <= '0;
      end else if (fifo_rd) begin
         consumed <= consumed + 1'b1;
      end
   end

   generate
      if (LVL_W == META_W) begin : g_same
         assign level_ext = fifo_level;
      end else begin : g_pad
         assign level_ext = {{(META_W - LVL_W){1'b0}}, fifo_level};
      end
   endgenerate

   always_comb begin
      unique case (mode)
         fpg_pkg::META_FILL: meta = level_ext;
         default:            meta = consumed;
      endcase
   end
endmodule

// File: rtl/fpg_word.sv
module fpg_word #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned META_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [META_W-1:0] meta,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data
);
   localparam int unsigned SEQ_W = DATA_W - META_W;
   logic [SEQ_W-1:0] seq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq     <= '0;
         wr_en   <= 1'b0;
         wr_data <= '0;
      end else begin
         wr_en <= fire;
         if (fire) begin
            wr_data <= {meta, seq};
            seq     <= seq + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fpg_occ.sv
module fpg_occ #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned LVL_W = 9
) (
   input  logic [LVL_W-1:0] level,
   output logic             low,
   output logic             high
);
   localparam int unsigned LOW_TH  = fpg_pkg::pct_of(DEPTH, 30);
   localparam int unsigned HIGH_TH = fpg_pkg::pct_of(DEPTH, 70);

   initial begin : prm
      assert (LOW_TH < HIGH_TH && HIGH_TH <= DEPTH)
         else $fatal(1, "fpg_occ: thresholds out of order");
   end

   assign low  = (level <= LVL_W'(LOW_TH));
   assign high = (level >= LVL_W'(HIGH_TH));
endmodule

// File: rtl/fifo_probe_gen.sv
module fifo_probe_gen #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned META_W      = 16,
   parameter int unsigned DEPTH       = 256,
   parameter int unsigned DUTY_PERIOD = 4,
   parameter int unsigned DUTY_ON     = 3,
   localparam int unsigned LVL_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              rate_reduce,
   input  logic              stop_on_full,
   input  logic              meta_mode,
   input  logic              fifo_full,
   input  logic              fifo_rd,
   input  logic [LVL_W-1:0]  fifo_level,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              occ_low,
   output logic              occ_high
);
   initial begin : prm
      assert (META_W >= 1 && META_W < DATA_W)
         else $fatal(1, "fifo_probe_gen: META_W must leave room for the sequence");
      assert (DEPTH >= 4)
         else $fatal(1, "fifo_probe_gen: DEPTH too small");
   end

   logic              slot;
   logic              fire;
   logic [META_W-1:0] meta;

   fpg_duty #(.PERIOD(DUTY_PERIOD), .ON(DUTY_ON)) u_duty (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (run && rate_reduce),
      .slot   (slot)
   );

   fpg_meta #(.META_W(META_W), .LVL_W(LVL_W)) u_meta (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_rd    (fifo_rd),
      .fifo_level (fifo_level),
      .mode       (fpg_pkg::meta_mode_e'(meta_mode)),
      .meta       (meta)
   );

   assign fire = run && slot && !(stop_on_full && fifo_full);

   fpg_word #(.DATA_W(DATA_W), .META_W(META_W)) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .meta    (meta),
      .wr_en   (wr_en),
      .wr_data (wr_data)
   );

   fpg_occ #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_occ (
      .level (fifo_level),
      .low   (occ_low),
      .high  (occ_high)
   );
endmodule

// File: rtl/fpg_probe_chk.sv
module fpg_probe_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned META_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              rate_reduce,
   input logic              stop_on_full,
   input logic              fifo_full,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              occ_low,
   input logic              occ_high
);
   localparam int unsigned SEQ_W = DATA_W - META_W;

   logic [SEQ_W-1:0] last_seq;
   logic             have_last;
   logic             rate_q;
   logic [2:0]       burst;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_seq  <= '0;
         have_last <= 1'b0;
         rate_q    <= 1'b0;
         burst     <= '0;
      end else begin
         rate_q <= rate_reduce;
         if (wr_en) begin
            last_seq  <= wr_data[SEQ_W-1:0];
            have_last <= 1'b1;
         end
         if (!rate_q || !wr_en) burst <= '0;
         else if (burst != 3'd7) burst <= burst + 1'b1;
      end
   end

   AST_STOP_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_on_full && fifo_full) |=> !wr_en); // R7
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !wr_en); // R10
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> $stable(wr_data)); // R3
   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && have_last) |-> (wr_data[SEQ_W-1:0] == SEQ_W'(last_seq + 1'b1))); // R3
   AST_FIRST_SEQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !have_last) |-> (wr_data[SEQ_W-1:0] == '0)); // R1
   AST_DUTY_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      burst <= 3'd3); // R6
   AST_OCC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(occ_low && occ_high)); // R9
endmodule

bind fifo_probe_gen fpg_probe_chk #(.DATA_W(DATA_W), .META_W(META_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .run          (run),
   .rate_reduce  (rate_reduce),
   .stop_on_full (stop_on_full),
   .fifo_full    (fifo_full),
   .wr_en        (wr_en),
   .wr_data      (wr_data),
   .occ_low      (occ_low),
   .occ_high     (occ_high)
);

// File: tb/fifo_probe_gen_bench.sv
`timescale 1ns/1ps
module fifo_probe_gen_bench;
   localparam int DEPTH = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0, rate_reduce = 1'b0, stop_on_full = 1'b0, meta_mode = 1'b0;
   logic        fifo_full = 1'b0, fifo_rd = 1'b0;
   logic [8:0]  fifo_level = '0;
   logic        wr_en;
   logic [31:0] wr_data;
   logic        occ_low, occ_high;

   int checks = 0, fails = 0;
   int          cnt = 0;
   int          rd_pct = 50;
   logic [1:0]  ph = '0;
   logic [15:0] cons = '0, seq = '0;
   logic        exp_we = 1'b0;
   logic [31:0] exp_data = '0;
   int          full_writes = 0;
   int          reads_total = 0;

   always #5 clk = ~clk;

   fifo_probe_gen u_fifo_probe_gen (
      .clk(clk), .rst_n(rst_n), .run(run), .rate_reduce(rate_reduce),
      .stop_on_full(stop_on_full), .meta_mode(meta_mode), .fifo_full(fifo_full),
      .fifo_rd(fifo_rd), .fifo_level(fifo_level), .wr_en(wr_en), .wr_data(wr_data),
      .occ_low(occ_low), .occ_high(occ_high)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
      end
   endtask

   function automatic logic exp_low(input logic [8:0] l);
      return int'(l) <= (DEPTH * 30) / 100;
   endfunction
   function automatic logic exp_high(input logic [8:0] l);
      return int'(l) >= (DEPTH * 70) / 100;
   endfunction

   // One clock: predict, let the edge pass, check, then drive next inputs.
   task automatic cyc();
      logic slot, blocked, fire;
      logic [15:0] meta;
      string wtag;
      slot    = !rate_reduce || (ph != 2'd3);
      blocked = stop_on_full && fifo_full;
      fire    = run && slot && !blocked;
      meta    = meta_mode ? {7'b0, fifo_level} : cons;
      if (!run) wtag = "R10";
      else if (blocked) wtag = "R7";
      else if (!slot) wtag = "R6";
      else wtag = "R2";
      @(posedge clk);
      if (run && rate_reduce) ph = ph + 2'd1; else ph = 2'd0;
      if (fifo_rd) begin cons = cons + 16'd1; reads_total++; end
      if (fifo_rd) cnt = cnt - 1;
      if (exp_we && fifo_full && !stop_on_full) full_writes++;
      if (exp_we && cnt < DEPTH) cnt = cnt + 1;
      if (fire) begin
         exp_data = {meta, seq};
         seq = seq + 16'd1;
      end
      exp_we = fire;
      @(negedge clk);
      chk(wr_en == exp_we, wtag, {31'b0, wr_en}, {31'b0, exp_we});
      chk(wr_data[15:0] == exp_data[15:0], "R3", wr_data, exp_data);
      chk(wr_data[31:16] == exp_data[31:16], meta_mode ? "R5" : "R4", wr_data, exp_data);
      chk(occ_low == exp_low(fifo_level), "R9", {31'b0, occ_low}, {31'b0, exp_low(fifo_level)});
      chk(occ_high == exp_high(fifo_level), "R9", {31'b0, occ_high}, {31'b0, exp_high(fifo_level)});
      fifo_level = 9'(cnt);
      fifo_full  = (cnt == DEPTH);
      fifo_rd    = (cnt > 0) && (($urandom % 100) < rd_pct);
   endtask

   task automatic run_for(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      int seed_sink;
      seed_sink = $urandom(32'd1357);
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(wr_en == 1'b0, "R1", {31'b0, wr_en}, 32'd0);
      chk(wr_data == 32'd0, "R1", wr_data, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_en == 1'b0 && wr_data == 32'd0, "R1", wr_data, 32'd0);

      // R2 R3 R4: full rate, read-count metadata
      run = 1'b1; rd_pct = 50;
      run_for(2000);
      // R5 R7: fill-level metadata, stop on full, slow reader fills the FIFO
      meta_mode = 1'b1; stop_on_full = 1'b1; rd_pct = 30;
      run_for(3000);
      chk(cnt == DEPTH || cnt == DEPTH - 1, "R7", 32'(cnt), 32'(DEPTH));
      // R8: keep writing into a full FIFO
      stop_on_full = 1'b0; rd_pct = 10;
      run_for(1000);
      chk(full_writes > 0, "R8", 32'(full_writes), 32'd1);
      // R6: reduced rate with mixed metadata sources
      rate_reduce = 1'b1; rd_pct = 80;
      for (int k = 0; k < 20; k++) begin
         meta_mode    = $urandom % 2;
         stop_on_full = $urandom % 2;
         run_for(100);
      end
      // R10: run toggles randomly
      for (int k = 0; k < 400; k++) begin
         run         = ($urandom % 3) != 0;
         rate_reduce = $urandom % 2;
         run_for(1 + $urandom % 6);
      end
      // R4: wrap of the read counter
      run = 1'b1; rate_reduce = 1'b0; stop_on_full = 1'b0; meta_mode = 1'b0; rd_pct = 100;
      run_for(70000);
      chk(reads_total > 65536, "R4", 32'(reads_total), 32'd65537);
      run = 1'b0;
      run_for(10);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule